// File: doc/BRIEF.md
# Power-Fail Warning and Reset Sequencer

This block is a clocked supervisor. It sits between a set of analog comparators and a processor. The comparators report the supply voltage against two tolerance levels, and they report an early-warning sense voltage against a falling threshold and a rising threshold. The block turns these flags into three outputs:

- an active-low non-maskable interrupt that warns of an impending power loss;
- an active-high reset;
- an active-low reset, given as a pull-down enable because that pin is open-drain.

All flags and straps are asynchronous, so each one passes through a two-flop synchronizer before use.

A strap chooses whether the supply is judged against the tight (5%) level or the loose (10%) level. The reset outputs assert shortly after the chosen supply flag shows a fault. After the supply recovers, a saturating counter keeps reset asserted for a hold time set by parameters. If the supply drops out again during the hold, the count restarts. A second strap chooses how the sense input is detected:

- with the strap high, hysteresis is used between the two thresholds;
- with the strap low, detection is at the rising threshold only.

The interrupt is released as soon as the sense input is healthy and the supply is in tolerance. It does not wait for the reset hold, so the processor gets its warning well before reset.

Top module: `pfw_supervisor`

## Requirements
- R1: While and just after the logic reset `rst_n` is low, `sys_rst` = 1, `sys_rst_pd` = 1 and `pfi_n` = 0.
- R2: With `tol_strap` = 0 the supply counts as good only when `vcc_ok_tight` = 1. With `tol_strap` = 1 only `vcc_ok_loose` is used, and `vcc_ok_tight` has no effect.
- R3: When the selected supply flag goes low, `sys_rst` and `pfi_n` = 0 take effect on the 3rd rising clock edge after the change.
- R4: After the selected supply flag goes high, `sys_rst` stays 1 up to the (HOLD_CYCLES+2)th rising edge. It falls on the (HOLD_CYCLES+3)th edge. HOLD_CYCLES = CLK_FREQ_HZ/1000*HOLD_MS. The hold counter saturates and never wraps.
- R5: If the selected supply flag goes low during the hold, the count clears. The full hold is then measured again from the next recovery.
- R6: `sys_rst_pd` always equals `sys_rst`.
- R7: With `mode_strap` = 1 the warning state works as follows. It sets when `sense_below_fall` = 1. It clears when `sense_above_rise` = 1. When both flags are 0 it keeps its value.
- R8: With `mode_strap` = 0 the warning state equals NOT `sense_above_rise`, and `sense_below_fall` has no effect.
- R9: `pfi_n` = NOT (warning OR supply bad). It follows a change on the 3rd rising edge, independent of the reset hold, so `pfi_n` can be 0 while `sys_rst` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| tol_strap | input | 1 | Tolerance select: 0 = tight level, 1 = loose level |
| mode_strap | input | 1 | Sense detection: 1 = hysteresis, 0 = rising threshold only |
| vcc_ok_tight | input | 1 | Supply above the 5% trip level |
| vcc_ok_loose | input | 1 | Supply above the 10% trip level |
| sense_below_fall | input | 1 | Sense input below its falling threshold |
| sense_above_rise | input | 1 | Sense input above its rising threshold |
| pfi_n | output | 1 | Power-fail interrupt, active low |
| sys_rst | output | 1 | Processor reset, active high |
| sys_rst_pd | output | 1 | Pull-down enable for the open-drain active-low reset |

## Verification
A corrupted warning state would show on `pfi_n` three edges after the sense flags change. This is most visible in the both-flags-clear band, where only the stored state decides the output. A hold counter that is off by one, wraps, or fails to clear would move the release edge of `sys_rst` away from exactly HOLD_CYCLES+3 edges after recovery. That move is visible after one hold period. A wrong strap decode would show as reset following the unselected supply flag within three edges.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

    // Synchronizer bit positions for the flag bundle.
    localparam int unsigned IDX_TOL   = 0;
    localparam int unsigned IDX_MODE  = 1;
    localparam int unsigned IDX_TIGHT = 2;
    localparam int unsigned IDX_LOOSE = 3;
    localparam int unsigned IDX_BELOW = 4;
    localparam int unsigned IDX_ABOVE = 5;
    localparam int unsigned FLAG_W    = 6;

    typedef struct packed {
        logic rst;    // active-high reset
        logic nmi_n;  // active-low interrupt
    } pfw_out_t;

endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
    parameter int unsigned WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = async_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/pfw_sense_hyst.sv
module pfw_sense_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_hyst,
    input  logic below_fall,
    input  logic above_rise,
    output logic warn_next,
    output logic warn_o
);

    logic warn_q, warn_d;

    always_comb begin
        warn_d = warn_q;
        if (mode_hyst) begin
            // set wins over clear if both flags are reported together
            if (below_fall)      warn_d = 1'b1;
            else if (above_rise) warn_d = 1'b0;
        end else begin
            warn_d = !above_rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warn_q <= 1'b1;
        else        warn_q <= warn_d;
    end

    assign warn_next = warn_d;
    assign warn_o    = warn_q;

    assert_hyst_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hyst && !below_fall && !above_rise) |=> (warn_q == $past(warn_q)));
    assert_hyst_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hyst && below_fall) |=> warn_q);
    assert_rise_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_hyst) |=> (warn_q == !$past(above_rise)));

endmodule

// File: rtl/pfw_reset_hold.sv
module pfw_reset_hold #(
    parameter int unsigned HOLD_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good,
    output logic holding
);

    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] HOLD_L = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!supply_good)        cnt_d = '0;
        else if (cnt_q != HOLD_L) cnt_d = cnt_q + 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign holding = (cnt_q != HOLD_L);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= HOLD_L);
    assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_good && cnt_q == HOLD_L) |=> (cnt_q == HOLD_L));
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_good) |=> (cnt_q == '0));

endmodule

// File: rtl/pfw_supervisor.sv
module pfw_supervisor #(
    parameter int unsigned CLK_FREQ_HZ = 50_000_000,
    parameter int unsigned HOLD_MS     = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tol_strap,
    input  logic mode_strap,
    input  logic vcc_ok_tight,
    input  logic vcc_ok_loose,
    input  logic sense_below_fall,
    input  logic sense_above_rise,
    output logic pfi_n,
    output logic sys_rst,
    output logic sys_rst_pd
);
    import pfw_pkg::*;

    localparam int unsigned HOLD_CYCLES = CLK_FREQ_HZ / 1000 * HOLD_MS;

    logic [FLAG_W-1:0] raw_flags;
    logic [FLAG_W-1:0] flags_s;
    logic              supply_good;
    logic              warn_next;
    logic              warn_cur;
    logic              holding;
    pfw_out_t          out_q, out_d;

    always_comb begin
        raw_flags            = '0;
        raw_flags[IDX_TOL]   = tol_strap;
        raw_flags[IDX_MODE]  = mode_strap;
        raw_flags[IDX_TIGHT] = vcc_ok_tight;
        raw_flags[IDX_LOOSE] = vcc_ok_loose;
        raw_flags[IDX_BELOW] = sense_below_fall;
        raw_flags[IDX_ABOVE] = sense_above_rise;
    end

    pfw_sync #(.WIDTH(FLAG_W), .RST_VAL('0)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_flags),
        .sync_o (flags_s)
    );

    assign supply_good = flags_s[IDX_TOL] ? flags_s[IDX_LOOSE] : flags_s[IDX_TIGHT];

    pfw_sense_hyst u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_hyst (flags_s[IDX_MODE]),
        .below_fall(flags_s[IDX_BELOW]),
        .above_rise(flags_s[IDX_ABOVE]),
        .warn_next (warn_next),
        .warn_o    (warn_cur)
    );

    pfw_reset_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_good(supply_good),
        .holding    (holding)
    );

    always_comb begin
        out_d.rst   = !supply_good || holding;
        out_d.nmi_n = !(warn_next || !supply_good);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.rst   <= 1'b1;
            out_q.nmi_n <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sys_rst    = out_q.rst;
    assign sys_rst_pd = out_q.rst;
    assign pfi_n      = out_q.nmi_n;

    assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_good) |=> (sys_rst && !pfi_n));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        holding |=> sys_rst);
    assert_warn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        warn_cur |-> !pfi_n);

endmodule

// File: tb/pfw_supervisor_bench.sv
`timescale 1ns/1ps
module pfw_supervisor_bench;

    localparam int unsigned FREQ = 100_000;
    localparam int unsigned HMS  = 1;
    localparam int unsigned HOLD = FREQ / 1000 * HMS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tol_strap = 1'b0, mode_strap = 1'b1;
    logic vcc_ok_tight = 1'b0, vcc_ok_loose = 1'b0;
    logic sense_below_fall = 1'b1, sense_above_rise = 1'b0;
    logic pfi_n, sys_rst, sys_rst_pd;

    int checks = 0;
    int errors = 0;
    bit model_warn;

    always #2.5 clk = ~clk;

    pfw_supervisor #(.CLK_FREQ_HZ(FREQ), .HOLD_MS(HMS)) u_pfw_supervisor (
        .clk(clk), .rst_n(rst_n), .tol_strap(tol_strap), .mode_strap(mode_strap),
        .vcc_ok_tight(vcc_ok_tight), .vcc_ok_loose(vcc_ok_loose),
        .sense_below_fall(sense_below_fall), .sense_above_rise(sense_above_rise),
        .pfi_n(pfi_n), .sys_rst(sys_rst), .sys_rst_pd(sys_rst_pd)
    );

    function automatic bit next_warn(bit cur, bit mode, bit below, bit above);
        if (mode) return below ? 1'b1 : (above ? 1'b0 : cur);
        return !above;
    endfunction

    function automatic bit exp_pfi_n(bit warn, bit good);
        return !(warn || !good);
    endfunction

    task automatic chk(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b exp %0b", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout exp completion");
        summary();
    end

    initial begin
        // R1: reset state
        cyc(3);
        chk(sys_rst, 1'b1, "R1 sys_rst");
        chk(sys_rst_pd, 1'b1, "R1 sys_rst_pd");
        chk(pfi_n, 1'b0, "R1 pfi_n");
        rst_n = 1'b1;
        cyc(1);
        chk(sys_rst, 1'b1, "R1 after release");

        // R4: power-up hold, tight tolerance
        sense_below_fall = 1'b0; sense_above_rise = 1'b1;
        vcc_ok_tight = 1'b1; vcc_ok_loose = 1'b1;
        cyc(3);
        chk(pfi_n, 1'b1, "R9 released during hold");
        chk(sys_rst, 1'b1, "R9 reset still held");
        cyc(HOLD - 1);
        chk(sys_rst, 1'b1, "R4 held at HOLD+2");
        cyc(1);
        chk(sys_rst, 1'b0, "R4 released at HOLD+3");
        chk(sys_rst_pd, 1'b0, "R6 pd follows");
        cyc(3 * HOLD);
        chk(sys_rst, 1'b0, "R4 saturates, no wrap");

        // R3: supply drop
        vcc_ok_tight = 1'b0;
        cyc(2);
        chk(sys_rst, 1'b0, "R3 not before 3rd edge");
        cyc(1);
        chk(sys_rst, 1'b1, "R3 reset on 3rd edge");
        chk(sys_rst_pd, 1'b1, "R6 pd on drop");
        chk(pfi_n, 1'b0, "R3 pfi_n on drop");

        // R5: restart during hold
        vcc_ok_tight = 1'b1;
        cyc(HOLD / 2);
        vcc_ok_tight = 1'b0;
        cyc(4);
        chk(sys_rst, 1'b1, "R5 dropout in hold");
        vcc_ok_tight = 1'b1;
        cyc(HOLD + 2);
        chk(sys_rst, 1'b1, "R5 full hold again");
        cyc(1);
        chk(sys_rst, 1'b0, "R5 release after full hold");

        // R2: loose tolerance ignores tight flag
        tol_strap = 1'b1; vcc_ok_tight = 1'b0; vcc_ok_loose = 1'b1;
        cyc(HOLD + 4);
        chk(sys_rst, 1'b0, "R2 tight ignored when loose");
        tol_strap = 1'b0;
        cyc(3);
        chk(sys_rst, 1'b1, "R2 tight used when strap low");
        vcc_ok_tight = 1'b1; tol_strap = 1'b1; vcc_ok_loose = 1'b0;
        cyc(3);
        chk(sys_rst, 1'b1, "R2 loose flag used");
        vcc_ok_loose = 1'b1;
        cyc(HOLD + 4);
        chk(sys_rst, 1'b0, "R2 recovery on loose");

        // R7/R8/R9: random sense stimulus with good supply
        model_warn = 1'b0;
        void'($urandom(1234));
        for (int i = 0; i < 400; i++) begin
            int sel;
            bit b, a;
            if (($urandom % 8) == 0) mode_strap = $urandom % 2;
            sel = $urandom % 3;
            b = (sel == 1);
            a = (sel == 2);
            sense_below_fall = b; sense_above_rise = a;
            model_warn = next_warn(model_warn, mode_strap, b, a);
            cyc(3);
            chk(pfi_n, exp_pfi_n(model_warn, 1'b1),
                mode_strap ? "R7 hysteresis" : "R8 rise only");
            chk(sys_rst, 1'b0, "R9 reset independent of warning");
            cyc(1);
        end

        // R7: directed band hold both ways
        mode_strap = 1'b1;
        sense_below_fall = 1'b1; sense_above_rise = 1'b0; cyc(4);
        sense_below_fall = 1'b0; cyc(4);
        chk(pfi_n, 1'b0, "R7 band keeps warning");
        sense_above_rise = 1'b1; cyc(4);
        sense_above_rise = 1'b0; cyc(4);
        chk(pfi_n, 1'b1, "R7 band keeps clear");
        // R8: below flag has no effect
        mode_strap = 1'b0; sense_above_rise = 1'b1; sense_below_fall = 1'b1; cyc(4);
        chk(pfi_n, 1'b1, "R8 below ignored");

        // R9: supply fault forces pfi_n low with healthy sense
        vcc_ok_loose = 1'b0; cyc(3);
        chk(pfi_n, 1'b0, "R9 supply bad");
        vcc_ok_loose = 1'b1; cyc(3);
        chk(pfi_n, 1'b1, "R9 released before reset");
        chk(sys_rst, 1'b1, "R9 reset still held");

        // R1: logic reset mid-run
        rst_n = 1'b0; cyc(1);
        chk(sys_rst, 1'b1, "R1 mid reset rst");
        chk(pfi_n, 1'b0, "R1 mid reset pfi_n");

        summary();
    end

endmodule